// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block models a single-clock synchronous static RAM. The array is organised as words of `NUM_BYTES` lanes, each lane 9 bits wide. Address, select, write enable and the per-lane write enables are all registered on the rising clock edge. Read data passes through two register stages: the array read register, then an output register. A read is therefore presented on the bus two edges after it is issued, and a new read can start on every edge.

A write supplies its data one edge after its address. That address and its lane enables wait in a one-entry buffer until the data edge, and the buffer entry is committed on that edge. A read issued on the same edge as the commit gets the new bytes from the buffer, merged lane by lane with the stored word.

A tri-state bus is stood in for by the read data output plus a drive flag. The drive flag follows the pipelined command. An asynchronous output enable also gates it, and so does a sleep input.

Top module: `sram_lw_pipe`

## Requirements
- R1: A read (`sel_ni`=0, `we_ni`=1, `sleep_i`=0 at rising edge n) puts the addressed word on `rdata_o` with `drive_o`=1 after edge n+1, given `oe_ni`=0. Reads issued on consecutive edges return their words on consecutive cycles.
- R2: A write (`sel_ni`=0, `we_ni`=0 at edge n) takes its data from `wdata_i` at edge n+1. A later read returns that data.
- R3: A deselect (`sel_ni`=1) at edge n leaves the data of a read from edge n-1 driven after edge n. `drive_o` is 0 after edge n+1.
- R4: A write command at edge n sets `drive_o` to 0 after edge n+1. The data of a read from edge n-1 is still driven after edge n.
- R5: Lane b of the word is bits [9b+8:9b]. A write updates lane b only when `be_ni[b]` was 0 on the address edge. The other lanes keep their previous contents.
- R6: A write with all of `be_ni` high changes no stored bit.
- R7: `oe_ni` acts without a clock. While it is 1, `drive_o` is 0. `rdata_o` is all zero whenever `drive_o` is 0. Returning `oe_ni` to 0 within the cycle brings back the held read data.
- R8: A read issued on the data edge of a write to the same address returns the new lanes merged with the old ones. A read of a different address on that edge returns only its stored word.
- R9: While `sleep_i` is 1, `drive_o` is 0 at once, and commands sampled on those edges are ignored. Stored contents survive sleep.
- R10: While `rst_ni` is low and after its release, `drive_o` is 0 and `rdata_o` is zero until a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep: ignore commands and float the bus |
| sel_ni | input | 1 | Select, active low |
| we_ni | input | 1 | Write enable, active low |
| be_ni | input | NUM_BYTES | Per-lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 9*NUM_BYTES | Write data, one edge after the address |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 9*NUM_BYTES | Read data, zero when not driven |
| drive_o | output | 1 | Bus-driven flag standing in for tri-state |

## Verification
The bench builds the block with `ADDR_W`=3 and `NUM_BYTES`=4. With eight words, every word is written before any read, so each read has a defined expected value. Four lanes allow lane-enable patterns that leave written and unwritten lanes interleaved, which is what the merge in the forwarding path has to get right. The 36-bit words also carry distinct per-lane values, so a lane taken from the wrong source shows up.

// File: rtl/sram_lw_pkg.sv
package sram_lw_pkg;
  localparam int unsigned BYTE_W = 9;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;
endpackage

// File: rtl/sram_lw_array.sv
module sram_lw_array #(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned NUM_BYTES = 4
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         wr_en_i,
  input  logic [ADDR_W-1:0]                            wr_addr_i,
  input  logic [NUM_BYTES-1:0]                         wr_mask_i,
  input  logic [NUM_BYTES*sram_lw_pkg::BYTE_W-1:0]     wr_data_i,
  input  logic                                         rd_en_i,
  input  logic [ADDR_W-1:0]                            rd_addr_i,
  output logic [NUM_BYTES*sram_lw_pkg::BYTE_W-1:0]     rd_data_o
);
  localparam int unsigned BW     = sram_lw_pkg::BYTE_W;
  localparam int unsigned DATA_W = NUM_BYTES * BW;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int b = 0; b < NUM_BYTES; b++) begin
        if (wr_mask_i[b]) mem_q[wr_addr_i][b*BW +: BW] <= wr_data_i[b*BW +: BW];
      end
    end
    // read sees pre-write contents; the buffer forwards same-edge commits
    if (rd_en_i) rd_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;

  // an aborted write must never reach the array
  p_mask_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (|wr_mask_i));
endmodule

// File: rtl/sram_lw_wbuf.sv
module sram_lw_wbuf #(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned NUM_BYTES = 4
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     cap_i,
  input  logic [ADDR_W-1:0]                        addr_i,
  input  logic [NUM_BYTES-1:0]                     be_ni,
  input  logic [NUM_BYTES*sram_lw_pkg::BYTE_W-1:0] wdata_i,
  input  logic                                     rd_en_i,
  output logic                                     commit_o,
  output logic [ADDR_W-1:0]                        cm_addr_o,
  output logic [NUM_BYTES-1:0]                     cm_mask_o,
  output logic [NUM_BYTES*sram_lw_pkg::BYTE_W-1:0] cm_data_o,
  output logic [NUM_BYTES-1:0]                     fwd_mask_o,
  output logic [NUM_BYTES*sram_lw_pkg::BYTE_W-1:0] fwd_data_o
);
  localparam int unsigned DATA_W = NUM_BYTES * sram_lw_pkg::BYTE_W;

  logic                 pend_v_q;
  logic [ADDR_W-1:0]    pend_addr_q;
  logic [NUM_BYTES-1:0] pend_mask_q;
  logic [NUM_BYTES-1:0] fwd_mask_q;
  logic [DATA_W-1:0]    fwd_data_q;
  logic                 hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q    <= 1'b0;
      pend_addr_q <= '0;
      pend_mask_q <= '0;
    end else begin
      pend_v_q <= cap_i;
      if (cap_i) begin
        pend_addr_q <= addr_i;
        pend_mask_q <= ~be_ni;
      end
    end
  end

  assign commit_o  = pend_v_q && (|pend_mask_q);
  assign cm_addr_o = pend_addr_q;
  assign cm_mask_o = pend_mask_q;
  assign cm_data_o = wdata_i;

  // a read on the commit edge of the same word takes the arriving lanes
  assign hit = pend_v_q && (pend_addr_q == addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_mask_q <= '0;
      fwd_data_q <= '0;
    end else if (rd_en_i) begin
      fwd_mask_q <= hit ? pend_mask_q : '0;
      fwd_data_q <= wdata_i;
    end
  end

  assign fwd_mask_o = fwd_mask_q;
  assign fwd_data_o = fwd_data_q;

  p_commit_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !(&be_ni)) |=> commit_o);
  p_abort_skip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && (&be_ni)) |=> !commit_o);
endmodule

// File: rtl/sram_lw_rdpipe.sv
module sram_lw_rdpipe #(
  parameter int unsigned NUM_BYTES = 4
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     rd_en_i,
  input  logic [NUM_BYTES*sram_lw_pkg::BYTE_W-1:0] raw_i,
  input  logic [NUM_BYTES-1:0]                     fwd_mask_i,
  input  logic [NUM_BYTES*sram_lw_pkg::BYTE_W-1:0] fwd_data_i,
  output logic [NUM_BYTES*sram_lw_pkg::BYTE_W-1:0] out_o,
  output logic                                     drv_o
);
  localparam int unsigned BW     = sram_lw_pkg::BYTE_W;
  localparam int unsigned DATA_W = NUM_BYTES * BW;

  logic              rd_v_q;
  logic              drv_q;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] merged;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_merge
    assign merged[b*BW +: BW] = fwd_mask_i[b] ? fwd_data_i[b*BW +: BW] : raw_i[b*BW +: BW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_v_q <= 1'b0;
      drv_q  <= 1'b0;
      out_q  <= '0;
    end else begin
      rd_v_q <= rd_en_i;
      drv_q  <= rd_v_q;
      if (rd_v_q) out_q <= merged;
    end
  end

  assign out_o = out_q;
  assign drv_o = drv_q;
endmodule

// File: rtl/sram_lw_pipe.sv
module sram_lw_pipe #(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned NUM_BYTES = 4
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     sleep_i,
  input  logic                                     sel_ni,
  input  logic                                     we_ni,
  input  logic [NUM_BYTES-1:0]                     be_ni,
  input  logic [ADDR_W-1:0]                        addr_i,
  input  logic [NUM_BYTES*sram_lw_pkg::BYTE_W-1:0] wdata_i,
  input  logic                                     oe_ni,
  output logic [NUM_BYTES*sram_lw_pkg::BYTE_W-1:0] rdata_o,
  output logic                                     drive_o
);
  import sram_lw_pkg::*;

  localparam int unsigned DATA_W = NUM_BYTES * BYTE_W;

  cmd_e                 cmd;
  logic                 rd_cmd;
  logic                 wr_cmd;
  logic                 commit;
  logic [ADDR_W-1:0]    cm_addr;
  logic [NUM_BYTES-1:0] cm_mask;
  logic [DATA_W-1:0]    cm_data;
  logic [NUM_BYTES-1:0] fwd_mask;
  logic [DATA_W-1:0]    fwd_data;
  logic [DATA_W-1:0]    raw;
  logic [DATA_W-1:0]    out;
  logic                 drv;

  always_comb begin
    cmd = CMD_IDLE;
    if (!sleep_i && !sel_ni) cmd = we_ni ? CMD_READ : CMD_WRITE;
  end

  assign rd_cmd = (cmd == CMD_READ);
  assign wr_cmd = (cmd == CMD_WRITE);

  sram_lw_wbuf #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_wbuf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (wr_cmd),
    .addr_i     (addr_i),
    .be_ni      (be_ni),
    .wdata_i    (wdata_i),
    .rd_en_i    (rd_cmd),
    .commit_o   (commit),
    .cm_addr_o  (cm_addr),
    .cm_mask_o  (cm_mask),
    .cm_data_o  (cm_data),
    .fwd_mask_o (fwd_mask),
    .fwd_data_o (fwd_data)
  );

  sram_lw_array #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (commit),
    .wr_addr_i (cm_addr),
    .wr_mask_i (cm_mask),
    .wr_data_i (cm_data),
    .rd_en_i   (rd_cmd),
    .rd_addr_i (addr_i),
    .rd_data_o (raw)
  );

  sram_lw_rdpipe #(.NUM_BYTES(NUM_BYTES)) u_rdpipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_cmd),
    .raw_i      (raw),
    .fwd_mask_i (fwd_mask),
    .fwd_data_i (fwd_data),
    .out_o      (out),
    .drv_o      (drv)
  );

  assign drive_o = drv && !oe_ni && !sleep_i;
  assign rdata_o = drive_o ? out : '0;

  p_read_drive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd |=> ##1 drv);
  p_desel_hiz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> ##1 !drv);
  p_write_hiz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd |=> ##1 !drv);
  p_sleep_hiz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ##1 !drv);
endmodule

// File: tb/sram_lw_pipe_tb.sv
module sram_lw_pipe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int NB = 4;
  localparam int DW = NB * 9;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sleep;
  logic          sel_n;
  logic          we_n;
  logic [NB-1:0] be_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          oe_n;
  logic [DW-1:0] rdata;
  logic          drive;

  logic [DW-1:0] mem_m [WORDS];
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lw_pipe #(.ADDR_W(AW), .NUM_BYTES(NB)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .sleep_i (sleep),
    .sel_ni  (sel_n),
    .we_ni   (we_n),
    .be_ni   (be_n),
    .addr_i  (addr),
    .wdata_i (wdata),
    .oe_ni   (oe_n),
    .rdata_o (rdata),
    .drive_o (drive)
  );

  task automatic chk(string req, logic exp_drv, logic [DW-1:0] exp_d);
    total++;
    if (drive !== exp_drv || rdata !== exp_d) begin
      bad++;
      $display("FAIL %s: drive=%b rdata=%h expected drive=%b rdata=%h",
               req, drive, rdata, exp_drv, exp_d);
    end
  endtask

  task automatic set_idle();
    sel_n = 1'b1; we_n = 1'b1; be_n = '1;
  endtask

  task automatic issue_read(int a);
    sel_n = 1'b0; we_n = 1'b1; be_n = '1; addr = AW'(a);
  endtask

  task automatic issue_write(int a, logic [NB-1:0] be);
    sel_n = 1'b0; we_n = 1'b0; be_n = be; addr = AW'(a);
  endtask

  task automatic model_write(int a, logic [NB-1:0] be, logic [DW-1:0] d);
    for (int b = 0; b < NB; b++)
      if (!be[b]) mem_m[a][b*9 +: 9] = d[b*9 +: 9];
  endtask

  task automatic do_write(int a, logic [NB-1:0] be, logic [DW-1:0] d);
    @(negedge clk); issue_write(a, be);
    @(negedge clk); wdata = d; set_idle(); model_write(a, be, d);
  endtask

  task automatic read_check(string req, int a);
    @(negedge clk); issue_read(a);
    @(negedge clk); set_idle();
    @(negedge clk); chk(req, 1'b1, mem_m[a]);
  endtask

  function automatic logic [DW-1:0] fill_val(int i);
    return {9'(i*37 + 5), 9'(i*11 + 300), 9'(i*7 + 130), 9'(i*3 + 17)};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; sleep = 1'b0; oe_n = 1'b0; addr = '0; wdata = '0;
    set_idle();
    repeat (3) @(negedge clk);
    chk("R10", 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", 1'b0, '0);
  endtask

  task automatic t_fill_and_stream();
    for (int i = 0; i < WORDS; i++) do_write(i, '0, fill_val(i));
    // back-to-back reads: data for read k appears two negedges later
    for (int k = 0; k < WORDS + 2; k++) begin
      @(negedge clk);
      if (k >= 2) chk("R1 R2", 1'b1, mem_m[k-2]);
      if (k < WORDS) issue_read(k); else set_idle();
    end
  endtask

  task automatic t_deselect();
    @(negedge clk); issue_read(1);
    @(negedge clk); set_idle();
    @(negedge clk); chk("R3", 1'b1, mem_m[1]);
    @(negedge clk); chk("R3", 1'b0, '0);
  endtask

  task automatic t_write_hiz();
    @(negedge clk); issue_read(4);
    @(negedge clk); issue_write(7, 4'b0000);
    @(negedge clk); chk("R4", 1'b1, mem_m[4]);
    wdata = 36'h9_8765_4321; set_idle(); model_write(7, 4'b0000, 36'h9_8765_4321);
    @(negedge clk); chk("R4", 1'b0, '0);
    read_check("R4", 7);
  endtask

  task automatic t_lanes();
    do_write(2, 4'b1010, 36'hA_AAAA_AAAA);
    read_check("R5", 2);
    do_write(0, 4'b0111, 36'h5_5555_5555);
    read_check("R5", 0);
  endtask

  task automatic t_abort();
    logic [DW-1:0] old = mem_m[3];
    do_write(3, 4'b1111, ~old);
    total++;
    if (mem_m[3] !== old) begin bad++; $display("FAIL R6: model changed"); end
    read_check("R6", 3);
  endtask

  task automatic t_oe();
    @(negedge clk); issue_read(5);
    @(negedge clk); set_idle();
    @(negedge clk); chk("R7", 1'b1, mem_m[5]);
    oe_n = 1'b1; #1 chk("R7", 1'b0, '0);
    oe_n = 1'b0; #1 chk("R7", 1'b1, mem_m[5]);
    @(negedge clk); chk("R7", 1'b0, '0);
  endtask

  task automatic t_coherent();
    @(negedge clk); issue_write(6, 4'b1100);
    @(negedge clk); wdata = 36'h1_2312_3123; model_write(6, 4'b1100, 36'h1_2312_3123);
    issue_read(6);
    @(negedge clk); set_idle();
    @(negedge clk); chk("R8", 1'b1, mem_m[6]);
    read_check("R8", 6);
    @(negedge clk); issue_write(6, 4'b0000);
    @(negedge clk); wdata = 36'h0_FEDC_BA98; model_write(6, 4'b0000, 36'h0_FEDC_BA98);
    issue_read(1);
    @(negedge clk); set_idle();
    @(negedge clk); chk("R8", 1'b1, mem_m[1]);
    read_check("R8", 6);
  endtask

  task automatic t_sleep();
    @(negedge clk); sleep = 1'b1; issue_write(1, 4'b0000);
    @(negedge clk); wdata = 36'hF_0F0F_0F0F; issue_read(1);
    @(negedge clk); chk("R9", 1'b0, '0); sleep = 1'b0; set_idle();
    @(negedge clk); chk("R9", 1'b0, '0);
    read_check("R9", 1);
    @(negedge clk); issue_read(2);
    @(negedge clk); set_idle(); sleep = 1'b1;
    @(negedge clk); chk("R9", 1'b0, '0);
    sleep = 1'b0; #1 chk("R9", 1'b1, mem_m[2]);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill_and_stream();
    t_deselect();
    t_write_hiz();
    t_lanes();
    t_abort();
    t_oe();
    t_coherent();
    t_sleep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule